// File: doc/BRIEF.md
# Profiling Event Ring-Buffer Recorder

This block turns profiling events into fixed 32-byte records and stores them in a circular buffer in memory. Each accepted event becomes four 64-bit words, written one at a time through a word-wide memory write port that may stall. Software loads a configuration with a single load pulse. The configuration gives the buffer base, the size in bytes, the starting head offset, a fill threshold, a sampling interval and a flag word. Software reports how far it has consumed through a tail offset input.

Two event kinds produce records. The software-inserted event (identifier 255) is recorded on every occurrence. The value-sampling event (identifier 1) is recorded only when its flag is set, and then only once every interval+1 occurrences. If the ring has no room, the event is dropped and a 64-bit missed-events counter advances. An interrupt level shows when the fill level has reached the threshold. A load with a zero base address turns recording off, but a record that is part-way out to memory still finishes first.

Top module: `evt_ring_recorder`

## Requirements
- R1: After reset the block is inactive, not busy, not writing, with head offset 0, missed count 0 and interrupt low.
- R2: A record is four 64-bit words written to base+head+0, +8, +16 and +24, in that order. Word 0 holds the event identifier in bits 7:0, the CORE_ID parameter in bits 15:8, zero in bits 31:16 and data1 in bits 63:32. Word 1 is the instruction address, word 2 is data2 and word 3 is zero.
- R3: Every accepted event with identifier 255 produces exactly one record.
- R4: An event with identifier 1 counts only while bit 1 of the flag word is set. The event counter is loaded with the interval at configuration load. Each counted event decrements the counter. An event that finds it at zero emits a record and reloads the counter, so an interval of N yields one record per N+1 events.
- R5: Events with any other identifier are ignored.
- R6: The head offset advances by 32 only after word 3 is accepted. It wraps to 0 when it reaches the buffer size.
- R7: When head+32 (modulo the size) equals the tail, the ring is full. A record-producing event is then dropped, no write takes place, and the missed count rises by one.
- R8: While a record is being written, busy is high and events are not accepted. A word not accepted by mem_ready is held unchanged on the port.
- R9: irq is high exactly when the block is active, flag bit 31 is set, and (head − tail) modulo size is at least the threshold. A threshold above the size never raises it.
- R10: A load with base 0 makes the block inactive. If a record is in flight, it is completed first and the block goes inactive in the same cycle its last word is accepted. A load with a non-zero base is ignored while busy.
- R11: While inactive, events produce no writes and leave the head and missed count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_load | input | 1 | Configuration load strobe |
| ctl_flags | input | 32 | Flag word (bit 1 value-event enable, bit 31 interrupt enable) |
| ctl_base | input | 64 | Buffer base address; zero means disable |
| ctl_size | input | 28 | Buffer size in bytes |
| ctl_head | input | 32 | Initial head offset |
| ctl_thresh | input | 32 | Fill threshold in bytes |
| ctl_interval | input | 26 | Sampling interval for the value event |
| sw_tail | input | 32 | Tail offset owned by software |
| evt_valid | input | 1 | Event present |
| evt_id | input | 8 | Event identifier |
| evt_data1 | input | 32 | First data value |
| evt_data2 | input | 64 | Second data value |
| evt_ip | input | 64 | Instruction address |
| mem_ready | input | 1 | Memory accepts the current word |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| busy | output | 1 | Record write in progress |
| active | output | 1 | Recording enabled |
| head_off | output | 32 | Current head offset |
| missed_cnt | output | 64 | Missed-events count |
| irq | output | 1 | Threshold interrupt level |

## Verification
On every cycle, the assertions check four things: a stalled word stays stable, the first word of a record carries a legal identifier, the missed count never steps by more than one, and an inactive recorder starts no writes. They also check that the interrupt never rises without an active configuration, and that the head moves whenever a write finishes. Whether the sampling ratio is right, whether overflow drops the right events, whether the head wraps at the right offset, and whether the flush-on-disable ordering holds depend on sequences of events and tail positions. Only the bench scenarios can show these, compared against the behavioural model.

// File: rtl/evt_ring_recorder.sv
module evt_ring_recorder #(
  parameter int AW = 64,
  parameter int OW = 32,
  parameter int SW = 28,
  parameter int IW = 26,
  parameter logic [7:0] CORE_ID = 8'h03,
  parameter logic [7:0] VAL_ID = 8'd1,
  parameter logic [7:0] INS_ID = 8'd255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_load,
  input  logic [31:0]   ctl_flags,
  input  logic [AW-1:0] ctl_base,
  input  logic [SW-1:0] ctl_size,
  input  logic [OW-1:0] ctl_head,
  input  logic [OW-1:0] ctl_thresh,
  input  logic [IW-1:0] ctl_interval,
  input  logic [OW-1:0] sw_tail,
  input  logic          evt_valid,
  input  logic [7:0]    evt_id,
  input  logic [31:0]   evt_data1,
  input  logic [63:0]   evt_data2,
  input  logic [AW-1:0] evt_ip,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [63:0]   mem_wdata,
  output logic          busy,
  output logic          active,
  output logic [OW-1:0] head_off,
  output logic [63:0]   missed_cnt,
  output logic          irq
);
  localparam int REC_BYTES = 32;
  localparam int WORDS = REC_BYTES / 8;
  localparam int BW = $clog2(WORDS);

  logic          stop_pend;
  logic [BW-1:0] beat;
  logic [IW-1:0] cnt, ivl;
  logic [31:0]   flags;
  logic [AW-1:0] base;
  logic [SW-1:0] size;
  logic [OW-1:0] thresh;
  logic [63:0]   rec [WORDS];

  wire [OW-1:0] size_w   = OW'(size);
  wire [OW-1:0] head_inc = head_off + OW'(REC_BYTES);
  wire [OW-1:0] head_nxt = (head_inc == size_w) ? '0 : head_inc;
  wire          full     = (head_nxt == sw_tail);
  wire [OW-1:0] fill     = (head_off >= sw_tail) ? head_off - sw_tail
                                                 : head_off + size_w - sw_tail;
  wire ctl_stop = ctl_load && (ctl_base == '0);
  wire wr_done  = busy && mem_ready && (beat == BW'(WORDS - 1));
  wire go_idle  = (ctl_stop || stop_pend) && (!busy || wr_done);
  wire take     = evt_valid && active && !busy && !ctl_load;
  wire is_ins   = (evt_id == INS_ID);
  wire is_val   = (evt_id == VAL_ID) && flags[1];
  wire fire     = take && (is_ins || (is_val && cnt == '0));

  assign mem_we    = busy;
  assign mem_addr  = base + AW'(head_off) + AW'({beat, 3'b000});
  assign mem_wdata = rec[beat];
  assign irq       = active && flags[31] && (fill >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      stop_pend  <= 1'b0;
      busy       <= 1'b0;
      beat       <= '0;
      head_off   <= '0;
      missed_cnt <= '0;
      cnt        <= '0;
      ivl        <= '0;
      flags      <= '0;
      base       <= '0;
      size       <= '0;
      thresh     <= '0;
      for (int i = 0; i < WORDS; i++) rec[i] <= '0;
    end else begin
      stop_pend <= (ctl_stop || stop_pend) && !go_idle;
      if (go_idle) begin
        active <= 1'b0;
      end else if (ctl_load && !ctl_stop && !busy) begin
        active   <= 1'b1;
        flags    <= ctl_flags;
        base     <= ctl_base;
        size     <= ctl_size;
        thresh   <= ctl_thresh;
        ivl      <= ctl_interval;
        cnt      <= ctl_interval;
        head_off <= ctl_head;
      end
      if (take && is_val) cnt <= (cnt == '0) ? ivl : cnt - 1'b1;
      if (fire) begin
        if (full) begin
          missed_cnt <= missed_cnt + 64'd1;
        end else begin
          busy   <= 1'b1;
          beat   <= '0;
          rec[0] <= {evt_data1, 16'h0000, CORE_ID, evt_id};
          rec[1] <= 64'(evt_ip);
          rec[2] <= evt_data2;
          rec[3] <= 64'd0;
        end
      end
      if (busy && mem_ready) begin
        if (wr_done) begin
          busy     <= 1'b0;
          head_off <= head_nxt;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/evt_ring_recorder_chk.sv
module evt_ring_recorder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        active,
  input logic        mem_we,
  input logic        mem_ready,
  input logic [63:0] mem_addr,
  input logic [63:0] mem_wdata,
  input logic [31:0] head_off,
  input logic [63:0] missed_cnt,
  input logic        irq
);
  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && !mem_ready |=> mem_we && $stable(mem_addr) && $stable(mem_wdata));

  assert_word0_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> (mem_wdata[7:0] == 8'd1 || mem_wdata[7:0] == 8'd255));

  assert_missed_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    missed_cnt == $past(missed_cnt) || missed_cnt == $past(missed_cnt) + 64'd1);

  assert_irq_needs_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> active);

  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !$rose(mem_we));

  assert_head_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> head_off != $past(head_off));
endmodule

bind evt_ring_recorder evt_ring_recorder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .active(active), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .head_off(head_off), .missed_cnt(missed_cnt), .irq(irq)
);

// File: tb/test_evt_ring_recorder.sv
module test_evt_ring_recorder;
  localparam int PERIOD = 10;
  localparam logic [7:0] CID = 8'h03;

  logic clk = 0, rst_n = 0;
  logic ctl_load = 0;
  logic [31:0] ctl_flags = 0;
  logic [63:0] ctl_base = 0;
  logic [27:0] ctl_size = 0;
  logic [31:0] ctl_head = 0, ctl_thresh = 0, sw_tail = 0;
  logic [25:0] ctl_interval = 0;
  logic evt_valid = 0;
  logic [7:0] evt_id = 0;
  logic [31:0] evt_data1 = 0;
  logic [63:0] evt_data2 = 0, evt_ip = 0;
  logic mem_ready = 1;
  logic mem_we, busy, active, irq;
  logic [63:0] mem_addr, mem_wdata, missed_cnt;
  logic [31:0] head_off;

  evt_ring_recorder i_evt_ring_recorder (
    .clk(clk), .rst_n(rst_n), .ctl_load(ctl_load), .ctl_flags(ctl_flags),
    .ctl_base(ctl_base), .ctl_size(ctl_size), .ctl_head(ctl_head),
    .ctl_thresh(ctl_thresh), .ctl_interval(ctl_interval), .sw_tail(sw_tail),
    .evt_valid(evt_valid), .evt_id(evt_id), .evt_data1(evt_data1),
    .evt_data2(evt_data2), .evt_ip(evt_ip), .mem_ready(mem_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .active(active), .head_off(head_off), .missed_cnt(missed_cnt), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, seq = 0;
  int rec255 = 0, rec1 = 0;
  bit stall = 0, done = 0, prev_we = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model
  bit m_active = 0, m_busy = 0, m_stop = 0;
  int unsigned m_beat = 0, m_head = 0, m_size = 0, m_thr = 0, m_cnt = 0, m_ivl = 0;
  logic [31:0] m_flags = 0;
  logic [63:0] m_base = 0, m_missed = 0;
  logic [63:0] m_rec [4];

  always @(posedge clk) begin
    bit was_busy, fin, stop_req, accept, emit;
    int unsigned nh;
    if (!rst_n) begin
      m_active = 0; m_busy = 0; m_stop = 0; m_beat = 0; m_head = 0;
      m_missed = 0; m_cnt = 0; m_flags = 0;
    end else begin
      was_busy = m_busy;
      fin = m_busy && mem_ready && m_beat == 3;
      stop_req = ctl_load && ctl_base == 0;
      accept = evt_valid && m_active && !m_busy && !ctl_load;
      nh = (m_head + 32 == m_size) ? 0 : m_head + 32;
      emit = 0;
      if (accept) begin
        if (evt_id == 8'd255) emit = 1;
        else if (evt_id == 8'd1 && m_flags[1]) begin
          if (m_cnt == 0) begin emit = 1; m_cnt = m_ivl; end
          else m_cnt = m_cnt - 1;
        end
        if (emit) begin
          if (nh == sw_tail) m_missed = m_missed + 1;
          else begin
            m_busy = 1; m_beat = 0;
            m_rec[0] = {evt_data1, 16'h0, CID, evt_id};
            m_rec[1] = evt_ip; m_rec[2] = evt_data2; m_rec[3] = 0;
          end
        end
      end
      if (was_busy && mem_ready) begin
        if (fin) begin m_busy = 0; m_head = nh; end
        else m_beat = m_beat + 1;
      end
      if (stop_req || m_stop) begin
        if (!was_busy || fin) begin m_active = 0; m_stop = 0; end
        else m_stop = 1;
      end else if (ctl_load && !was_busy) begin
        m_active = 1; m_flags = ctl_flags; m_base = ctl_base; m_size = ctl_size;
        m_thr = ctl_thresh; m_ivl = ctl_interval; m_cnt = ctl_interval; m_head = ctl_head;
      end
    end
  end

  always @(posedge clk) begin
    int unsigned fill;
    #1;
    if (rst_n && !done) begin
      fill = (m_head >= sw_tail) ? m_head - sw_tail : m_head + m_size - sw_tail;
      check("R8 busy", busy, m_busy);
      check("R8 mem_we", mem_we, m_busy);
      if (m_busy) begin
        check("R2 addr", mem_addr, m_base + 64'(m_head) + 64'(8 * m_beat));
        check("R2 data", mem_wdata, m_rec[m_beat]);
      end
      check("R6 head", head_off, m_head);
      check("R7 missed", missed_cnt, m_missed);
      check("R10 active", active, m_active);
      check("R9 irq", irq, m_active && m_flags[31] && fill >= m_thr);
      if (mem_we && !prev_we) begin
        if (mem_wdata[7:0] == 8'd255) rec255++;
        if (mem_wdata[7:0] == 8'd1) rec1++;
      end
      prev_we = mem_we;
    end
  end

  always @(negedge clk) begin
    cyc++;
    mem_ready <= stall ? (cyc % 3 == 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 60000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic load(logic [63:0] b, logic [27:0] s, logic [31:0] h,
                      logic [31:0] th, logic [31:0] f, logic [25:0] iv);
    @(negedge clk);
    while (busy) @(negedge clk);
    ctl_base = b; ctl_size = s; ctl_head = h; ctl_thresh = th;
    ctl_flags = f; ctl_interval = iv; ctl_load = 1;
    @(negedge clk);
    ctl_load = 0;
  endtask

  task automatic send(logic [7:0] id);
    @(negedge clk);
    while (busy) @(negedge clk);
    seq++;
    evt_id = id; evt_valid = 1;
    evt_data1 = 32'hA500_0000 + seq;
    evt_data2 = 64'h1111_2222_0000_0000 + 64'(seq * 7);
    evt_ip = 64'h0000_7F00_0000_0000 + 64'(seq * 4);
    @(negedge clk);
    evt_valid = 0;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 head", head_off, 0);
    check("R1 missed", missed_cnt, 0);
    check("R1 irq", irq, 0);
    check("R1 active", active, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // A: sampled value events, inserted events, ignored ids, wrap, stalls
    stall = 1;
    sw_tail = 32'hC0;
    load(64'h1000, 28'd256, 32'hC0, 32'd96, 32'h8000_0002, 26'd2);
    repeat (3) send(8'd255);
    repeat (7) send(8'd1);
    settle();
    check("R6 wrap head", head_off, 32'h60);
    repeat (2) send(8'd7);
    settle();
    check("R5 ignored ids", head_off, 32'h60);
    check("R9 irq above threshold", irq, 1);

    // B: overflow
    stall = 0;
    repeat (4) send(8'd255);
    settle();
    check("R7 missed after full", missed_cnt, 2);
    check("R7 head at full", head_off, 32'hA0);

    // C: software drains
    sw_tail = 32'hA0;
    @(negedge clk);
    check("R9 irq after drain", irq, 0);

    // D: value event disabled, threshold above size
    sw_tail = 0;
    load(64'h2000, 28'd256, 32'h0, 32'd300, 32'h8000_0000, 26'd0);
    repeat (5) send(8'd1);
    settle();
    check("R4 value events off", head_off, 0);
    repeat (6) send(8'd255);
    settle();
    check("R9 threshold over size", irq, 0);
    check("R3 head after six", head_off, 32'hC0);

    // E: disable during a write
    sw_tail = 32'hC0;
    stall = 1;
    send(8'd255);
    ctl_base = 0; ctl_load = 1;
    @(negedge clk);
    ctl_load = 0;
    check("R10 still active mid-record", active, 1);
    settle();
    check("R10 inactive after drain", active, 0);
    check("R10 record drained", head_off, 32'hE0);

    // F: events while inactive
    stall = 0;
    send(8'd255);
    settle();
    check("R11 head idle", head_off, 32'hE0);
    check("R11 missed idle", missed_cnt, 2);

    check("R3 inserted record count", rec255, 12);
    check("R4 sampled record count", rec1, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule